// File: doc/BRIEF.md
# RISC Instruction Decoder

This block is the decode stage of a small 32-bit load-store processor. It is purely combinational. It takes one fixed-width instruction word and cuts it into its fields: the operation code, two source register numbers, a destination register number, a shift amount, a function code, a 16-bit immediate and a 26-bit jump target. From the operation code, and from the function code when the operation code is zero, it derives every control line the datapath needs. These lines cover the register write and its target, the ALU operation and its second operand, how the immediate is widened, memory read or write with access size, the branch condition, the jump kind and the link write.

The surrounding datapath holds the register file, the ALU and memory. It uses the read-enable outputs to know which source registers an instruction really depends on, for example when it checks hazards. Any word that falls outside the supported set raises an illegal flag. An illegal word also clears every side effect, so the pipeline can drop it or trap on it safely. A parameter can disable the byte-sized loads and stores, and they then decode as illegal.

Top module: `rdec_top`

## Requirements
- R1: The fields are cut from fixed positions: operation code [31:26], first source [25:21], second source [20:16], destination [15:11], shift amount [10:6], function code [5:0], immediate [15:0], jump target [25:0]. They are passed through unchanged for every word, legal or not.
- R2: Operation code 0 with function code 32, 34 or 42 selects add, subtract or set-less-than. The ALU code is 0, 1 or 2. The register write targets the destination field. Both sources are read, and the second ALU operand is the register.
- R3: Operation codes 8, 10, 13 and 15 select add-immediate (ALU 0, sign extend), set-less-than-immediate (ALU 2, sign extend), or-immediate (ALU 3, zero extend) and load-upper (ALU 4, upper placement). Each writes the second-source field and takes the immediate as ALU operand. The first source is read by all of them except load-upper.
- R4: Operation code 35 is a word load and 32 is a byte load. Each raises memory read, writes the second-source field, uses ALU add with a sign-extended immediate operand and reads the first source. The size code is 0 for word and 1 for byte.
- R5: Operation code 43 is a word store and 40 is a byte store. Each raises memory write, writes no register, uses ALU add with a sign-extended immediate and reads both sources. Memory read and memory write are never raised together.
- R6: Operation codes 4 and 5 are branch-if-equal (branch code 1) and branch-if-not-equal (branch code 2). They use ALU subtract, read both sources and write nothing. Every other instruction gives branch code 0.
- R7: Operation code 2 is a jump to the target field (jump code 1). Operation code 3 does the same jump, raises link and writes register 31. Operation code 0 with function code 8 is a jump through the first source (jump code 2), which it reads, and writes nothing. A branch and a jump are never decoded from the same word.
- R8: Any other operation code, or function code under operation code 0, raises illegal. It then clears register write, write target, memory read and write, branch, jump, link and both read enables.
- R9: When a control line has no use for an instruction, it takes a fixed value: write target 0 when nothing is written, ALU code 0, extension code 0 (codes: 0 sign, 1 zero, 2 upper), size 0, and register operand select.
- R10: The shift amount field never changes any control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| opcode_o | output | 6 | Operation code field |
| rs_o | output | 5 | First source register number |
| rt_o | output | 5 | Second source register number |
| rd_o | output | 5 | Destination register field |
| shamt_o | output | 5 | Shift amount field |
| funct_o | output | 6 | Function code field |
| imm_o | output | 16 | Immediate field |
| target_o | output | 26 | Jump target field |
| rs_rd_o | output | 1 | Instruction reads the first source |
| rt_rd_o | output | 1 | Instruction reads the second source |
| reg_we_o | output | 1 | Register write enable |
| wr_reg_o | output | 5 | Register number written |
| alu_op_o | output | 3 | ALU operation code |
| ext_o | output | 2 | Immediate extension mode |
| alu_imm_o | output | 1 | Second ALU operand is the immediate |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_size_o | output | 1 | Access size, 0 word, 1 byte |
| branch_o | output | 2 | Branch condition |
| jump_o | output | 2 | Jump kind |
| link_o | output | 1 | Return address written to register 31 |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
Two pairs of functions fire in the same word. A jump-and-link starts a jump and writes register 31 at once, and a store raises a memory write while it reads both source registers. Each cycle the bench applies one word. Some words come from every supported encoding with random surrounding fields, and the others come from exhaustive sweeps of all 64 operation codes and all 64 function codes. Every output is compared against a behavioural model written from the requirements. The combined cases count as correct only when the jump kind, link, write enable and write target (or the memory write and both read enables) all match in the same cycle.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

   localparam int unsigned INSN_W = 32;
   localparam int unsigned OP_W   = 6;
   localparam int unsigned REG_W  = 5;
   localparam int unsigned FN_W   = 6;
   localparam int unsigned IMM_W  = 16;
   localparam int unsigned TGT_W  = 26;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_SLT = 3'd2,
      ALU_OR  = 3'd3,
      ALU_LUI = 3'd4
   } alu_e;

   typedef enum logic [1:0] {
      EXT_SIGN  = 2'd0,
      EXT_ZERO  = 2'd1,
      EXT_UPPER = 2'd2
   } ext_e;

   typedef enum logic {
      SZ_WORD = 1'b0,
      SZ_BYTE = 1'b1
   } size_e;

   typedef enum logic [1:0] {
      BR_NONE = 2'd0,
      BR_EQ   = 2'd1,
      BR_NE   = 2'd2
   } br_e;

   typedef enum logic [1:0] {
      JMP_NONE = 2'd0,
      JMP_TGT  = 2'd1,
      JMP_REG  = 2'd2
   } jmp_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_RD   = 2'd1,
      DST_RT   = 2'd2,
      DST_LINK = 2'd3
   } dst_e;

   // operation codes
   localparam logic [OP_W-1:0] OPC_REG   = 6'd0;
   localparam logic [OP_W-1:0] OPC_J     = 6'd2;
   localparam logic [OP_W-1:0] OPC_JAL   = 6'd3;
   localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
   localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
   localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
   localparam logic [OP_W-1:0] OPC_SLTI  = 6'd10;
   localparam logic [OP_W-1:0] OPC_ORI   = 6'd13;
   localparam logic [OP_W-1:0] OPC_LUI   = 6'd15;
   localparam logic [OP_W-1:0] OPC_LDB   = 6'd32;
   localparam logic [OP_W-1:0] OPC_LDW   = 6'd35;
   localparam logic [OP_W-1:0] OPC_STB   = 6'd40;
   localparam logic [OP_W-1:0] OPC_STW   = 6'd43;

   // function codes under operation code 0
   localparam logic [FN_W-1:0] FN_JR  = 6'd8;
   localparam logic [FN_W-1:0] FN_ADD = 6'd32;
   localparam logic [FN_W-1:0] FN_SUB = 6'd34;
   localparam logic [FN_W-1:0] FN_SLT = 6'd42;

   typedef struct packed {
      logic  legal;
      dst_e  dst;
      alu_e  alu;
      ext_e  ext;
      logic  src_imm;
      logic  mem_rd;
      logic  mem_wr;
      size_e size;
      br_e   br;
      jmp_e  jmp;
      logic  link;
      logic  rs_rd;
      logic  rt_rd;
   } ctrl_t;

endpackage

// File: rtl/rdec_fields.sv
module rdec_fields
   import rdec_pkg::*;
#(
   parameter int unsigned WORD_W = INSN_W
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [OP_W-1:0]   op_o,
   output logic [REG_W-1:0]  rs_o,
   output logic [REG_W-1:0]  rt_o,
   output logic [REG_W-1:0]  rd_o,
   output logic [REG_W-1:0]  shamt_o,
   output logic [FN_W-1:0]   fn_o,
   output logic [IMM_W-1:0]  imm_o,
   output logic [TGT_W-1:0]  tgt_o
);

   localparam int unsigned OP_LSB = WORD_W - OP_W;
   localparam int unsigned RS_LSB = OP_LSB - REG_W;
   localparam int unsigned RT_LSB = RS_LSB - REG_W;
   localparam int unsigned RD_LSB = RT_LSB - REG_W;
   localparam int unsigned SH_LSB = RD_LSB - REG_W;

   generate
      if (WORD_W != OP_W + 3*REG_W + REG_W + FN_W) begin : g_bad_width
         $error("rdec_fields: word width must equal the sum of the field widths");
      end
      if (IMM_W != REG_W + REG_W + FN_W) begin : g_bad_imm
         $error("rdec_fields: immediate must cover destination, shift and function fields");
      end
   endgenerate

   assign op_o    = word_i[OP_LSB +: OP_W];
   assign rs_o    = word_i[RS_LSB +: REG_W];
   assign rt_o    = word_i[RT_LSB +: REG_W];
   assign rd_o    = word_i[RD_LSB +: REG_W];
   assign shamt_o = word_i[SH_LSB +: REG_W];
   assign fn_o    = word_i[0 +: FN_W];
   assign imm_o   = word_i[0 +: IMM_W];
   assign tgt_o   = word_i[0 +: TGT_W];

endmodule

// File: rtl/rdec_ctrl.sv
module rdec_ctrl
   import rdec_pkg::*;
#(
   parameter bit SUPPORT_BYTE = 1'b1
) (
   input  logic [OP_W-1:0] op_i,
   input  logic [FN_W-1:0] fn_i,
   output ctrl_t           ctrl_o
);

   logic  byte_ok;
   ctrl_t reg_ctrl;
   ctrl_t op_ctrl;

   generate
      if (SUPPORT_BYTE) begin : g_byte_on
         assign byte_ok = 1'b1;
      end else begin : g_byte_off
         assign byte_ok = 1'b0;
      end
   endgenerate

   // function code sub-decode for operation code 0
   always_comb begin
      reg_ctrl = '0;
      unique case (fn_i)
         FN_ADD, FN_SUB, FN_SLT: begin
            reg_ctrl.legal = 1'b1;
            reg_ctrl.dst   = DST_RD;
            reg_ctrl.rs_rd = 1'b1;
            reg_ctrl.rt_rd = 1'b1;
            reg_ctrl.alu   = (fn_i == FN_ADD) ? ALU_ADD :
                             (fn_i == FN_SUB) ? ALU_SUB : ALU_SLT;
         end
         FN_JR: begin
            reg_ctrl.legal = 1'b1;
            reg_ctrl.jmp   = JMP_REG;
            reg_ctrl.rs_rd = 1'b1;
         end
         default: reg_ctrl = '0;
      endcase
   end

   // operation code decode
   always_comb begin
      op_ctrl = '0;
      unique case (op_i)
         OPC_REG: op_ctrl = reg_ctrl;
         OPC_ADDI, OPC_SLTI, OPC_ORI, OPC_LUI: begin
            op_ctrl.legal   = 1'b1;
            op_ctrl.dst     = DST_RT;
            op_ctrl.src_imm = 1'b1;
            op_ctrl.rs_rd   = (op_i != OPC_LUI);
            op_ctrl.alu     = (op_i == OPC_ADDI) ? ALU_ADD :
                              (op_i == OPC_SLTI) ? ALU_SLT :
                              (op_i == OPC_ORI)  ? ALU_OR  : ALU_LUI;
            op_ctrl.ext     = (op_i == OPC_ORI)  ? EXT_ZERO  :
                              (op_i == OPC_LUI)  ? EXT_UPPER : EXT_SIGN;
         end
         OPC_LDW, OPC_LDB: begin
            op_ctrl.legal   = (op_i == OPC_LDW) || byte_ok;
            op_ctrl.dst     = DST_RT;
            op_ctrl.src_imm = 1'b1;
            op_ctrl.mem_rd  = 1'b1;
            op_ctrl.rs_rd   = 1'b1;
            op_ctrl.size    = (op_i == OPC_LDB) ? SZ_BYTE : SZ_WORD;
         end
         OPC_STW, OPC_STB: begin
            op_ctrl.legal   = (op_i == OPC_STW) || byte_ok;
            op_ctrl.src_imm = 1'b1;
            op_ctrl.mem_wr  = 1'b1;
            op_ctrl.rs_rd   = 1'b1;
            op_ctrl.rt_rd   = 1'b1;
            op_ctrl.size    = (op_i == OPC_STB) ? SZ_BYTE : SZ_WORD;
         end
         OPC_BEQ, OPC_BNE: begin
            op_ctrl.legal = 1'b1;
            op_ctrl.alu   = ALU_SUB;
            op_ctrl.rs_rd = 1'b1;
            op_ctrl.rt_rd = 1'b1;
            op_ctrl.br    = (op_i == OPC_BEQ) ? BR_EQ : BR_NE;
         end
         OPC_J, OPC_JAL: begin
            op_ctrl.legal = 1'b1;
            op_ctrl.jmp   = JMP_TGT;
            op_ctrl.link  = (op_i == OPC_JAL);
            op_ctrl.dst   = (op_i == OPC_JAL) ? DST_LINK : DST_NONE;
         end
         default: op_ctrl = '0;
      endcase
   end

   assign ctrl_o = op_ctrl;

endmodule

// File: rtl/rdec_gate.sv
module rdec_gate
   import rdec_pkg::*;
#(
   parameter int unsigned LINK_REG = 31
) (
   input  ctrl_t            ctrl_i,
   input  logic [REG_W-1:0] rd_i,
   input  logic [REG_W-1:0] rt_i,
   output ctrl_t            ctrl_o,
   output logic             we_o,
   output logic [REG_W-1:0] wr_reg_o,
   output logic             illegal_o
);

   localparam logic [REG_W-1:0] LINK_NUM = REG_W'(LINK_REG);

   generate
      if (LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("rdec_gate: link register number does not fit the register field");
      end
   endgenerate

   // an illegal word leaves every side effect cleared
   assign ctrl_o    = ctrl_i.legal ? ctrl_i : '0;
   assign illegal_o = !ctrl_i.legal;
   assign we_o      = ctrl_i.legal && (ctrl_i.dst != DST_NONE);

   always_comb begin
      wr_reg_o = '0;
      if (ctrl_i.legal) begin
         unique case (ctrl_i.dst)
            DST_RD:   wr_reg_o = rd_i;
            DST_RT:   wr_reg_o = rt_i;
            DST_LINK: wr_reg_o = LINK_NUM;
            default:  wr_reg_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/rdec_top.sv
module rdec_top
   import rdec_pkg::*;
#(
   parameter bit          SUPPORT_BYTE = 1'b1,
   parameter int unsigned LINK_REG     = 31
) (
   input  logic [31:0] instr_i,
   output logic [5:0]  opcode_o,
   output logic [4:0]  rs_o,
   output logic [4:0]  rt_o,
   output logic [4:0]  rd_o,
   output logic [4:0]  shamt_o,
   output logic [5:0]  funct_o,
   output logic [15:0] imm_o,
   output logic [25:0] target_o,
   output logic        rs_rd_o,
   output logic        rt_rd_o,
   output logic        reg_we_o,
   output logic [4:0]  wr_reg_o,
   output logic [2:0]  alu_op_o,
   output logic [1:0]  ext_o,
   output logic        alu_imm_o,
   output logic        mem_rd_o,
   output logic        mem_wr_o,
   output logic        mem_size_o,
   output logic [1:0]  branch_o,
   output logic [1:0]  jump_o,
   output logic        link_o,
   output logic        illegal_o
);

   ctrl_t raw_ctrl;
   ctrl_t fin_ctrl;

   rdec_fields #(.WORD_W(INSN_W)) u_fields (
      .word_i  (instr_i),
      .op_o    (opcode_o),
      .rs_o    (rs_o),
      .rt_o    (rt_o),
      .rd_o    (rd_o),
      .shamt_o (shamt_o),
      .fn_o    (funct_o),
      .imm_o   (imm_o),
      .tgt_o   (target_o)
   );

   rdec_ctrl #(.SUPPORT_BYTE(SUPPORT_BYTE)) u_ctrl (
      .op_i   (opcode_o),
      .fn_i   (funct_o),
      .ctrl_o (raw_ctrl)
   );

   rdec_gate #(.LINK_REG(LINK_REG)) u_gate (
      .ctrl_i    (raw_ctrl),
      .rd_i      (rd_o),
      .rt_i      (rt_o),
      .ctrl_o    (fin_ctrl),
      .we_o      (reg_we_o),
      .wr_reg_o  (wr_reg_o),
      .illegal_o (illegal_o)
   );

   assign rs_rd_o    = fin_ctrl.rs_rd;
   assign rt_rd_o    = fin_ctrl.rt_rd;
   assign alu_op_o   = fin_ctrl.alu;
   assign ext_o      = fin_ctrl.ext;
   assign alu_imm_o  = fin_ctrl.src_imm;
   assign mem_rd_o   = fin_ctrl.mem_rd;
   assign mem_wr_o   = fin_ctrl.mem_wr;
   assign mem_size_o = fin_ctrl.size;
   assign branch_o   = fin_ctrl.br;
   assign jump_o     = fin_ctrl.jmp;
   assign link_o     = fin_ctrl.link;

   // checks across the field slicer, the decoder and the gating stage
   always_comb begin
      AST_ILLEGAL_QUIET: assert (!illegal_o || (!reg_we_o && !mem_rd_o && !mem_wr_o && (jump_o == 2'd0))); // R8
      AST_MEM_EXCL: assert (!(mem_rd_o && mem_wr_o)); // R5
      AST_FLOW_EXCL: assert (!((branch_o != 2'd0) && (jump_o != 2'd0))); // R7
      AST_LINK_WRITE: assert (!link_o || (reg_we_o && (wr_reg_o == 5'(LINK_REG)) && (jump_o == 2'd1))); // R7
      AST_WR_FIELD: assert (!reg_we_o || link_o || (wr_reg_o == rd_o) || (wr_reg_o == rt_o)); // R2
      AST_NO_WRITE_ZERO: assert (reg_we_o || (wr_reg_o == 5'd0)); // R9
      AST_LOAD_ALU: assert (!(mem_rd_o || mem_wr_o) || (alu_imm_o && (alu_op_o == 3'd0) && rs_rd_o)); // R4
   end

endmodule

// File: tb/rdec_top_bench.sv
module rdec_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = 32'd0;

   logic [5:0]  opcode;
   logic [4:0]  rs, rt, rd, shamt;
   logic [5:0]  funct;
   logic [15:0] imm;
   logic [25:0] target;
   logic        rs_rd, rt_rd, reg_we, alu_imm, mem_rd, mem_wr, mem_size, link, illegal;
   logic [4:0]  wr_reg;
   logic [2:0]  alu_op;
   logic [1:0]  ext, branch, jump;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;
   logic [31:0] lfsr = 32'hACE1_2357;

   // expected values
   int e_ill, e_we, e_wr, e_alu, e_ext, e_imm, e_mr, e_mw, e_sz, e_br, e_jp, e_lk, e_ru, e_tu;

   always #2 clk = ~clk;

   rdec_top u_rdec_top (
      .instr_i    (instr),
      .opcode_o   (opcode),
      .rs_o       (rs),
      .rt_o       (rt),
      .rd_o       (rd),
      .shamt_o    (shamt),
      .funct_o    (funct),
      .imm_o      (imm),
      .target_o   (target),
      .rs_rd_o    (rs_rd),
      .rt_rd_o    (rt_rd),
      .reg_we_o   (reg_we),
      .wr_reg_o   (wr_reg),
      .alu_op_o   (alu_op),
      .ext_o      (ext),
      .alu_imm_o  (alu_imm),
      .mem_rd_o   (mem_rd),
      .mem_wr_o   (mem_wr),
      .mem_size_o (mem_size),
      .branch_o   (branch),
      .jump_o     (jump),
      .link_o     (link),
      .illegal_o  (illegal)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish, got cycle %0d exp < 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   // behavioural model built from the requirement list
   task automatic model(input logic [31:0] w);
      int op, fn, f_rt, f_rd;
      op = int'(w[31:26]); fn = int'(w[5:0]);
      f_rt = int'(w[20:16]); f_rd = int'(w[15:11]);
      e_ill = 1; e_we = 0; e_wr = 0; e_alu = 0; e_ext = 0; e_imm = 0;
      e_mr = 0; e_mw = 0; e_sz = 0; e_br = 0; e_jp = 0; e_lk = 0; e_ru = 0; e_tu = 0;
      if (op == 0) begin
         if (fn == 32 || fn == 34 || fn == 42) begin          // R2
            e_ill = 0; e_we = 1; e_wr = f_rd; e_ru = 1; e_tu = 1;
            e_alu = (fn == 32) ? 0 : (fn == 34) ? 1 : 2;
         end else if (fn == 8) begin                         // R7 register jump
            e_ill = 0; e_jp = 2; e_ru = 1;
         end
      end else if (op == 8 || op == 10 || op == 13 || op == 15) begin   // R3
         e_ill = 0; e_we = 1; e_wr = f_rt; e_imm = 1;
         e_ru = (op == 15) ? 0 : 1;
         e_alu = (op == 8) ? 0 : (op == 10) ? 2 : (op == 13) ? 3 : 4;
         e_ext = (op == 13) ? 1 : (op == 15) ? 2 : 0;
      end else if (op == 35 || op == 32) begin               // R4
         e_ill = 0; e_we = 1; e_wr = f_rt; e_imm = 1; e_mr = 1; e_ru = 1;
         e_sz = (op == 32) ? 1 : 0;
      end else if (op == 43 || op == 40) begin               // R5
         e_ill = 0; e_imm = 1; e_mw = 1; e_ru = 1; e_tu = 1;
         e_sz = (op == 40) ? 1 : 0;
      end else if (op == 4 || op == 5) begin                 // R6
         e_ill = 0; e_alu = 1; e_ru = 1; e_tu = 1; e_br = (op == 4) ? 1 : 2;
      end else if (op == 2 || op == 3) begin                 // R7
         e_ill = 0; e_jp = 1;
         if (op == 3) begin e_lk = 1; e_we = 1; e_wr = 31; end
      end
   endtask

   task automatic chk(input string tag, input int got, input int exp, input logic [31:0] w);
      checks = checks + 1;
      if (got != exp) begin
         fails = fails + 1;
         $display("FAIL %s word %h: got %0d exp %0d", tag, w, got, exp);
      end
   endtask

   // drive one word at the rising edge, judge it at the falling edge
   task automatic apply(input logic [31:0] w);
      @(posedge clk);
      instr = w;
      @(negedge clk);
      model(w);
      chk("R1 opcode", int'(opcode), int'(w[31:26]), w);
      chk("R1 fields", int'({rs, rt, rd, shamt, funct}), int'(w[25:0]), w);
      chk("R1 imm/target", int'({imm, target}), int'({w[15:0], w[25:0]}), w);
      chk("R8 illegal", int'(illegal), e_ill, w);
      chk("R2 R3 R7 write", int'({reg_we, wr_reg}), (e_we << 5) | e_wr, w);
      chk("R3 R9 alu/ext/src", int'({alu_op, ext, alu_imm}), (e_alu << 3) | (e_ext << 1) | e_imm, w);
      chk("R4 R5 memory", int'({mem_rd, mem_wr, mem_size}), (e_mr << 2) | (e_mw << 1) | e_sz, w);
      chk("R6 R7 flow", int'({branch, jump, link}), (e_br << 3) | (e_jp << 1) | e_lk, w);
      chk("R8 reads", int'({rs_rd, rt_rd}), (e_ru << 1) | e_tu, w);
   endtask

   initial begin
      logic [31:0] w;
      logic [31:0] base;
      int legal_ops [12] = '{8, 10, 13, 15, 35, 32, 43, 40, 4, 5, 2, 3};
      int reg_fns [4] = '{32, 34, 42, 8};

      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset-state word: all zeros is operation 0, function 0, which is illegal (R8)
      apply(32'd0);

      // each supported encoding with random surrounding fields
      for (int n = 0; n < 40; n++) begin
         for (int k = 0; k < 12; k++) begin
            lfsr = next_rand(lfsr);
            apply({6'(legal_ops[k]), lfsr[25:0]});
         end
         for (int k = 0; k < 4; k++) begin
            lfsr = next_rand(lfsr);
            apply({6'd0, lfsr[25:6], 6'(reg_fns[k])});
         end
      end

      // jump-and-link together with a jump: link writes 31 (R7)
      apply({6'd3, 26'h3FF_FFFF});
      // store with both reads and a memory write (R5)
      apply({6'd43, 5'd31, 5'd31, 16'h8000});

      // shift amount sweep: never changes the control outputs (R10)
      for (int s = 0; s < 32; s++) begin
         apply({6'd0, 5'd3, 5'd4, 5'd5, 5'(s), 6'd34});
         apply({6'd0, 5'd3, 5'd4, 5'd5, 5'(s), 6'd9});
      end

      // every operation code (R8)
      for (int o = 0; o < 64; o++) begin
         for (int r = 0; r < 3; r++) begin
            lfsr = next_rand(lfsr);
            apply({6'(o), lfsr[25:0]});
         end
      end

      // every function code under operation code 0 (R2 R7 R8)
      for (int f = 0; f < 64; f++) begin
         lfsr = next_rand(lfsr);
         base = {6'd0, lfsr[25:6], 6'(f)};
         w = base;
         apply(w);
      end

      // fully random words
      for (int n = 0; n < 2000; n++) begin
         lfsr = next_rand(lfsr);
         apply(lfsr);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule